// File: doc/BRIEF.md
# Serial Flash Slave Command Engine

This block is the serial slave front end of a small byte-addressed flash-style memory. It takes the serial clock, chip select, serial data input and hold input of a mode-0 serial peripheral bus. It oversamples them in the system clock domain and decodes 8-bit commands. It forwards the resulting work as single-cycle requests to a memory controller. The controller owns the array, the status byte and the write-in-progress flag. The engine only shifts bits, decodes opcodes, captures addresses and streams bytes back on a serial output that has its own output-enable pin.

Bit 3 of every opcode is ignored. Each address is sent as three bytes, and only the low `ADDR_W` bits are kept. Reads stream one byte after another, and the address advances and wraps around the whole array. Program data stays inside its page. An identification read returns two fixed bytes. Three situations silence the engine until chip select is next released: an unknown opcode, any command other than the status read while the controller reports busy, and a command that has completed. The hold input pauses the transfer without losing its place.

Top module: `spi_flash_cmd_engine`

## Requirements
- R1: While chip select is high, `spi_so_oe` is 0 and input bits are not taken. Raising chip select before a command is complete discards it, so no request is issued and the next selection starts a fresh opcode.
- R2: Bits are taken MSB first on the rising serial clock, and bit 3 of the opcode is don't-care. `req_op` codes are: 1 write enable (0x06), 2 write disable (0x04), 3 status write (0x01), 4 program byte (0x02), 5 sector erase (0x52), 6 full erase (0x62).
- R3: An opcode outside the nine defined values issues no request, and it keeps `spi_so_oe` at 0 until chip select rises.
- R4: Identification (0x15) drives 0x1F, then 0x65, and then 0x00 bytes.
- R5: Status read (0x05) streams `ctl_status`, MSB first, for as many bytes as are clocked.
- R6: Data read (0x03) takes a 24-bit address, drops its upper 8 bits and streams `rd_data` for `rd_addr`. The address rises by one per byte and wraps from 0xFFFF to 0x0000.
- R7: Program (0x02) takes a 24-bit address. It then issues one op-4 request per complete data byte. The low 7 address bits wrap inside the 128-byte page, and the upper bits stay fixed.
- R8: Write enable, write disable and full erase issue their request after the 8th bit. Status write issues op 3, carrying the data byte, after the 16th bit. Sector erase issues op 5, carrying the captured address, after the 32nd bit. Further input in the same selection is ignored.
- R9: When `ctl_status[0]` is 1 at the 8th bit, every opcode except status read is locked out, as in R3.
- R10: Pulling `spi_hold_n` low while the clock is low forces `spi_so_oe` to 0 and ignores clock edges and input. Releasing it while the clock is low resumes the same bit sequence.
- R11: Output bits change after the detected falling clock edge. The first output bit is valid before the rising edge that follows the last command or address bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock, mode 0 |
| spi_si | input | 1 | Serial data in |
| spi_hold_n | input | 1 | Pause input, active low |
| spi_so | output | 1 | Serial data out |
| spi_so_oe | output | 1 | Output enable for `spi_so`; 0 means high impedance |
| ctl_status | input | 8 | Controller status byte; bit 0 is write-in-progress |
| req_valid | output | 1 | Single-cycle request strobe |
| req_op | output | 3 | Request code, as listed in R2 |
| req_addr | output | ADDR_W | Address for program and sector erase |
| req_data | output | 8 | Data for program and status write |
| rd_req | output | 1 | High in the cycle `rd_data` is taken for `rd_addr` |
| rd_addr | output | ADDR_W | Current array address |
| rd_data | input | 8 | Read data for `rd_addr`, valid in the same cycle |

## Verification
The hardest case to reach is a hold that lands in the middle of a byte. The pause has to begin and end while the clock is low, and clock edges and input changes during the pause must leave no trace. The stimulus does this during an identification byte and during an address byte. It clocks 4 bits, lowers hold, toggles the clock several times with the input driven high, and releases hold. The resumed byte must then assemble to the expected ID value or read address. A sweep over all 256 opcode values separately confirms the decode and the lockout for every don't-care combination.

// File: rtl/spi_flash_cmd_engine.sv
module spi_flash_cmd_engine #(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 7,
  parameter logic [7:0] MFR_ID = 8'h1F,
  parameter logic [7:0] DEV_ID = 8'h65
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_cs_n,
  input  logic              spi_sck,
  input  logic              spi_si,
  input  logic              spi_hold_n,
  output logic              spi_so,
  output logic              spi_so_oe,
  input  logic [7:0]        ctl_status,
  output logic              req_valid,
  output logic [2:0]        req_op,
  output logic [ADDR_W-1:0] req_addr,
  output logic [7:0]        req_data,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        rd_data
);
  localparam logic [7:0] OP_WREN = 8'h06, OP_WRDI = 8'h04, OP_STAT = 8'h05,
                         OP_WSTA = 8'h01, OP_READ = 8'h03, OP_PROG = 8'h02,
                         OP_SERA = 8'h52, OP_CERA = 8'h62, OP_IDNT = 8'h15;
  localparam logic [4:0] LAST_ADDR_BIT = 5'd23;

  typedef enum logic [2:0] {S_OPC, S_ADDR, S_WDAT, S_PDAT, S_OUT, S_DONE, S_LOCK} st_t;
  typedef enum logic [2:0] {K_NONE, K_STAT, K_ID, K_READ, K_PROG, K_SERA} kind_t;

  logic [2:0] sck_p;
  logic [1:0] cs_p, hold_p, si_p;
  logic held, out_on, so_q;
  st_t state;
  kind_t kind;
  logic [4:0] cnt;
  logic [2:0] obit;
  logic [1:0] id_n;
  logic [6:0] sr, osr;
  logic [ADDR_W-1:0] addr;
  logic [7:0] src;

  wire sck_s = sck_p[1];
  wire cs_s  = cs_p[1];
  wire si_s  = si_p[1];
  wire busy  = ctl_status[0];
  wire go_r  = sck_p[1] & ~sck_p[2] & ~cs_s & ~held;
  wire go_f  = ~sck_p[1] & sck_p[2] & ~cs_s & ~held;
  wire [7:0] shin = {sr, si_s};
  wire [7:0] op = shin & 8'hF7;
  wire [ADDR_W-1:0] addr_in = {addr[ADDR_W-2:0], si_s};

  assign spi_so    = so_q;
  assign spi_so_oe = out_on & ~held & ~cs_s;
  assign rd_addr   = addr;
  assign rd_req    = go_f && state == S_OUT && obit == 3'd0 && kind == K_READ;

  always_comb begin
    case (kind)
      K_STAT:  src = ctl_status;
      K_ID:    src = (id_n == 2'd0) ? MFR_ID : (id_n == 2'd1) ? DEV_ID : 8'h00;
      K_READ:  src = rd_data;
      default: src = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_p <= '0; si_p <= '0; cs_p <= 2'b11; hold_p <= 2'b11; held <= 1'b0;
    end else begin
      sck_p  <= {sck_p[1:0], spi_sck};
      si_p   <= {si_p[0], spi_si};
      cs_p   <= {cs_p[0], spi_cs_n};
      hold_p <= {hold_p[0], spi_hold_n};
      if (cs_s) held <= 1'b0;
      else if (!sck_s) held <= ~hold_p[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_OPC; kind <= K_NONE; cnt <= '0; obit <= '0; id_n <= '0;
      sr <= '0; osr <= '0; addr <= '0; out_on <= 1'b0; so_q <= 1'b0;
      req_valid <= 1'b0; req_op <= '0; req_addr <= '0; req_data <= '0;
    end else begin
      req_valid <= 1'b0;
      if (cs_s) begin
        state <= S_OPC; kind <= K_NONE; cnt <= '0; obit <= '0; id_n <= '0; out_on <= 1'b0;
      end else begin
        if (go_r) begin
          case (state)
            S_OPC: begin
              sr  <= shin[6:0];
              cnt <= cnt + 5'd1;
              if (cnt == 5'd7) begin
                cnt <= '0;
                if (busy && op != OP_STAT) state <= S_LOCK;
                else case (op)
                  OP_WREN: begin req_valid <= 1'b1; req_op <= 3'd1; state <= S_DONE; end
                  OP_WRDI: begin req_valid <= 1'b1; req_op <= 3'd2; state <= S_DONE; end
                  OP_CERA: begin req_valid <= 1'b1; req_op <= 3'd6; state <= S_DONE; end
                  OP_WSTA: state <= S_WDAT;
                  OP_STAT: begin kind <= K_STAT; state <= S_OUT; end
                  OP_IDNT: begin kind <= K_ID;   state <= S_OUT; end
                  OP_READ: begin kind <= K_READ; state <= S_ADDR; end
                  OP_PROG: begin kind <= K_PROG; state <= S_ADDR; end
                  OP_SERA: begin kind <= K_SERA; state <= S_ADDR; end
                  default: state <= S_LOCK;
                endcase
              end
            end
            S_ADDR: begin
              addr <= addr_in;
              cnt  <= cnt + 5'd1;
              if (cnt == LAST_ADDR_BIT) begin
                cnt <= '0;
                case (kind)
                  K_SERA: begin
                    req_valid <= 1'b1; req_op <= 3'd5; req_addr <= addr_in; state <= S_DONE;
                  end
                  K_READ:  state <= S_OUT;
                  default: state <= S_PDAT;
                endcase
              end
            end
            S_WDAT: begin
              sr  <= shin[6:0];
              cnt <= cnt + 5'd1;
              if (cnt == 5'd7) begin
                req_valid <= 1'b1; req_op <= 3'd3; req_data <= shin; state <= S_DONE;
              end
            end
            S_PDAT: begin
              sr  <= shin[6:0];
              cnt <= cnt + 5'd1;
              if (cnt == 5'd7) begin
                cnt <= '0;
                req_valid <= 1'b1; req_op <= 3'd4; req_addr <= addr; req_data <= shin;
                addr <= {addr[ADDR_W-1:PAGE_W], addr[PAGE_W-1:0] + 1'b1};
              end
            end
            default: ;
          endcase
        end
        if (go_f && state == S_OUT) begin
          out_on <= 1'b1;
          obit   <= obit + 3'd1;
          if (obit == 3'd0) begin
            so_q <= src[7];
            osr  <= src[6:0];
            if (kind == K_READ) addr <= addr + 1'b1;
            if (kind == K_ID && id_n != 2'd2) id_n <= id_n + 2'd1;
          end else begin
            so_q <= osr[6];
            osr  <= {osr[5:0], 1'b0};
          end
        end
      end
    end
  end

  p_deselect_hiz_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> !spi_so_oe);

  p_req_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_op >= 3'd1 && req_op <= 3'd6));

  p_lock_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_LOCK |-> (!spi_so_oe && !req_valid));

  p_busy_status_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == S_OPC && $past(busy) && state != S_OPC && state != S_LOCK)
      |-> (state == S_OUT && kind == K_STAT));

  p_hold_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (held && !cs_s) |=> ($stable(cnt) && $stable(state) && $stable(so_q) && $stable(addr)));

  p_page_stay_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 3'd4 && state == S_PDAT)
      |-> addr[ADDR_W-1:PAGE_W] == req_addr[ADDR_W-1:PAGE_W]);
endmodule

// File: tb/sim_spi_flash_cmd_engine.sv
module sim_spi_flash_cmd_engine;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1;
  logic so, oe, req_valid, rd_req;
  logic [7:0] status = 8'h00, req_data, rd_data;
  logic [2:0] req_op;
  logic [15:0] req_addr, rd_addr;

  int nchk = 0, nerr = 0, lg_n = 0;
  logic [2:0]  lg_op   [0:15];
  logic [15:0] lg_addr [0:15];
  logic [7:0]  lg_data [0:15];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_flash_cmd_engine u0 (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck), .spi_si(si),
    .spi_hold_n(hold_n), .spi_so(so), .spi_so_oe(oe), .ctl_status(status),
    .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data));

  function automatic logic [7:0] pat(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction
  assign rd_data = pat(rd_addr);

  always @(posedge clk) if (req_valid && lg_n < 16) begin
    lg_op[lg_n] <= req_op; lg_addr[lg_n] <= req_addr; lg_data[lg_n] <= req_data;
    lg_n <= lg_n + 1;
  end

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic tick_half;
    repeat (HALF) @(posedge clk);
    #1;
  endtask

  task automatic sel;
    cs_n = 1'b0; tick_half;
  endtask

  task automatic desel;
    tick_half; cs_n = 1'b1; tick_half; tick_half;
  endtask

  task automatic xbits(input logic [7:0] tx, input int n, output logic [7:0] rx, output logic oe_all);
    rx = '0; oe_all = 1'b1;
    for (int i = 7; i > 7 - n; i--) begin
      si = tx[i];
      tick_half;
      rx = {rx[6:0], so};
      if (!oe) oe_all = 1'b0;
      sck = 1'b1; tick_half; sck = 1'b0;
    end
  endtask

  task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx, output logic oe_all);
    xbits(tx, 8, rx, oe_all);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
      $finish;
    end
  end

  initial begin
    logic [7:0] rx, rx2;
    logic ok, ok2;
    int base;
    repeat (3) @(posedge clk); #1;
    rst_n = 1'b1;
    tick_half;
    chk("R1 reset oe", {31'b0, oe}, 0);
    chk("R1 reset req", {31'b0, req_valid}, 0);

    // R2 R3 R4 R5 R8: sweep every opcode value
    status = 8'h8C;
    for (int o = 0; o < 256; o++) begin
      logic [7:0] m;
      m = 8'(o) & 8'hF7;
      base = lg_n;
      sel; xbyte(8'(o), rx, ok); xbyte(8'h06, rx, ok2); desel;
      chk("R1 oe after deselect", {31'b0, oe}, 0);
      case (m)
        8'h06, 8'h04, 8'h62: begin
          chk("R2 R8 one request", lg_n - base, 1);
          chk("R2 op code", {29'b0, lg_op[base]}, (m == 8'h06) ? 1 : (m == 8'h04) ? 2 : 6);
          chk("R8 silent after", {31'b0, ok2}, 0);
        end
        8'h01: begin
          chk("R8 status write request", lg_n - base, 1);
          chk("R8 status write op", {29'b0, lg_op[base]}, 3);
          chk("R8 status write data", {24'b0, lg_data[base]}, 8'h06);
        end
        8'h05: begin
          chk("R5 oe", {31'b0, ok2}, 1);
          chk("R5 status byte", {24'b0, rx}, 8'h8C);
          chk("R5 no request", lg_n - base, 0);
        end
        8'h15: begin
          chk("R4 oe", {31'b0, ok2}, 1);
          chk("R4 first id", {24'b0, rx}, 8'h1F);
        end
        default: begin
          chk("R3 no request", lg_n - base, 0);
          chk("R3 oe low", {31'b0, ok2}, 0);
        end
      endcase
    end

    // R4 full ID sequence
    sel; xbyte(8'h1D, rx, ok); xbyte(0, rx, ok); xbyte(0, rx2, ok2);
    chk("R4 mfr", {24'b0, rx}, 8'h1F);
    chk("R4 dev", {24'b0, rx2}, 8'h65);
    xbyte(0, rx, ok);
    chk("R4 after ids", {24'b0, rx}, 8'h00);
    desel;

    // R5 repeated status with live value
    status = 8'h82;
    sel; xbyte(8'h05, rx, ok); xbyte(0, rx, ok); xbyte(0, rx2, ok2); desel;
    chk("R5 status first", {24'b0, rx}, 8'h82);
    chk("R5 status repeat", {24'b0, rx2}, 8'h82);

    // R6 R11 read with upper bits ignored and wrap
    status = 8'h00;
    sel; xbyte(8'h03, rx, ok); xbyte(8'hAB, rx, ok); xbyte(8'hFF, rx, ok); xbyte(8'hFE, rx, ok);
    chk("R11 no output during address", {31'b0, ok}, 0);
    for (int k = 0; k < 4; k++) begin
      xbyte(0, rx, ok);
      chk("R6 R11 read byte", {23'b0, ok, rx}, {23'b0, 1'b1, pat(16'hFFFE + 16'(k))});
    end
    desel;
    chk("R1 deselect after read", {31'b0, oe}, 0);

    // R6 address sweep
    for (int k = 0; k < 16; k++) begin
      logic [15:0] a;
      a = 16'(k * 4099 + 7);
      sel; xbyte(8'h0B, rx, ok); xbyte(8'(k), rx, ok); xbyte(a[15:8], rx, ok); xbyte(a[7:0], rx, ok);
      xbyte(0, rx, ok); xbyte(0, rx2, ok2); desel;
      chk("R6 sweep byte0", {24'b0, rx}, {24'b0, pat(a)});
      chk("R6 sweep byte1", {24'b0, rx2}, {24'b0, pat(a + 16'd1)});
    end

    // R7 program with page wrap
    base = lg_n;
    sel; xbyte(8'h02, rx, ok); xbyte(8'h12, rx, ok); xbyte(8'h34, rx, ok); xbyte(8'h7E, rx, ok);
    xbyte(8'hA1, rx, ok); xbyte(8'hB2, rx, ok); xbyte(8'hC3, rx, ok); xbits(8'hFF, 3, rx, ok); desel;
    chk("R7 three requests", lg_n - base, 3);
    chk("R7 req0", {lg_op[base], lg_addr[base], lg_data[base]}, {3'd4, 16'h347E, 8'hA1});
    chk("R7 req1", {lg_op[base+1], lg_addr[base+1], lg_data[base+1]}, {3'd4, 16'h347F, 8'hB2});
    chk("R7 req2 page wrap", {lg_op[base+2], lg_addr[base+2], lg_data[base+2]}, {3'd4, 16'h3400, 8'hC3});

    // R8 sector erase
    base = lg_n;
    sel; xbyte(8'h5A, rx, ok); xbyte(8'hFF, rx, ok); xbyte(8'h81, rx, ok); xbyte(8'h23, rx, ok);
    xbyte(8'h06, rx, ok); desel;
    chk("R8 sector erase one request", lg_n - base, 1);
    chk("R8 sector erase", {lg_op[base], lg_addr[base]}, {3'd5, 16'h8123});

    // R1 aborts
    base = lg_n;
    sel; xbyte(8'h02, rx, ok); xbyte(8'h00, rx, ok); xbyte(8'h12, rx, ok); xbyte(8'h34, rx, ok);
    xbits(8'hAA, 5, rx, ok); desel;
    sel; xbyte(8'h01, rx, ok); xbits(8'h55, 5, rx, ok); desel;
    sel; xbits(8'h06, 3, rx, ok); desel;
    chk("R1 aborted commands issue nothing", lg_n - base, 0);
    sel; xbyte(8'h15, rx, ok); xbyte(0, rx, ok); desel;
    chk("R1 fresh opcode after abort", {24'b0, rx}, 8'h1F);

    // R9 busy lockout
    status = 8'hFF;
    base = lg_n;
    sel; xbyte(8'h06, rx, ok); desel;
    sel; xbyte(8'h62, rx, ok); desel;
    chk("R9 no request while busy", lg_n - base, 0);
    sel; xbyte(8'h15, rx, ok); xbyte(0, rx, ok); desel;
    chk("R9 id ignored while busy", {31'b0, ok}, 0);
    sel; xbyte(8'h03, rx, ok); xbyte(0, rx, ok); xbyte(0, rx, ok); xbyte(0, rx, ok);
    xbyte(0, rx, ok); desel;
    chk("R9 read ignored while busy", {31'b0, ok}, 0);
    sel; xbyte(8'h05, rx, ok); xbyte(0, rx, ok); desel;
    chk("R9 status allowed while busy", {23'b0, ok, rx}, {23'b0, 1'b1, 8'hFF});
    status = 8'h00;

    // R10 hold during ID output
    sel; xbyte(8'h15, rx, ok); xbits(0, 4, rx, ok);
    hold_n = 1'b0; tick_half;
    chk("R10 oe off while held", {31'b0, oe}, 0);
    si = 1'b1;
    for (int t = 0; t < 3; t++) begin sck = 1'b1; tick_half; sck = 1'b0; tick_half; end
    hold_n = 1'b1; tick_half;
    xbits(0, 4, rx2, ok2);
    chk("R10 resumed id byte", {24'b0, rx[3:0], rx2[3:0]}, 8'h1F);
    xbyte(0, rx, ok);
    chk("R10 next id byte", {24'b0, rx}, 8'h65);
    desel;

    // R10 hold during address input
    sel; xbyte(8'h03, rx, ok); xbyte(8'h00, rx, ok); xbits(8'h12, 4, rx, ok);
    hold_n = 1'b0; tick_half;
    si = 1'b1;
    for (int t = 0; t < 4; t++) begin sck = 1'b1; tick_half; sck = 1'b0; tick_half; end
    hold_n = 1'b1; tick_half;
    xbits(8'h20, 4, rx, ok); xbyte(8'h34, rx, ok); xbyte(0, rx, ok); desel;
    chk("R10 held input ignored", {24'b0, rx}, {24'b0, pat(16'h1234)});

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
    $finish;
  end
endmodule